// File: doc/BRIEF.md
# Byte-Assembling Auto-Increment Register Port

This block is the host-facing register port of an 8-bit parallel peripheral. The host first sends an address byte. Its low five bits pick one of 32 internal registers, and its top three bits are compared with the board's own select code. Each later data byte reads or writes the chosen register, and the internal address then steps by one. Because of this, a whole run of registers can be streamed without sending a new address. For example, the host can fetch all twelve encoder bytes, or write all four duty values, in one burst.

Writes to wide destinations pass through a 24-bit assembly register. The lower bytes of a value only update the assembly register. The byte that completes the value sends the whole value to its destination as a single-cycle commit pulse with the full payload. As a result, no destination ever sees a mix of old and new bytes. Single-byte control registers are forwarded directly as a one-cycle write strobe. Reads come from a multiplexer over the encoder latches, a few auxiliary input bytes and a fixed identity code.

Top module: `regport_top`

## Requirements
- R1: A cycle with `addr_stb` high loads `host_wdata[4:0]` as the current register address. In the same cycle the board becomes selected exactly when `host_wdata[7:5]` equals `board_sel`, and `rdata_oe` shows the selection from the next cycle.
- R2: Each data strobe on a selected board, read or write, advances the address by one. The address wraps from 0x1F to 0x00.
- R3: While the board is not selected, data strobes have no effect. They produce no pulse and do not change `asm_value`, and `rdata_oe` is 0 with `host_rdata` at 0x00.
- R4: On a selected board, `host_rdata` for address a in 0..11 is byte a of `enc_pos`, `enc_pos[8a+7:8a]`. Axis n occupies bits 24n+23:24n, low byte first. Address 0x0F reads the fixed code 0x52.
- R5: Addresses 0x0C..0x0E read `aux_in` bytes 0..2, low byte first. Addresses 0x10..0x1F read 0x00.
- R6: A write to address 0, 1 or 2 replaces byte 0, 1 or 2 of the assembly register (`asm_value`). A write to address 2 also raises `asm_commit` for one cycle in the next cycle, with the completed 24-bit value on `asm_value`.
- R7: A write to 0x10+2n puts the byte into assembly byte 0. A write to 0x11+2n (n = 0..3) raises `duty_commit[n]` in the next cycle, with `duty_value` = {written byte, assembly byte 0}.
- R8: A write to 0x1D puts the byte into assembly byte 0. A write to 0x1E raises `freq_commit` in the next cycle, with `freq_value` = {written byte, assembly byte 0}.
- R9: A write to 0x03, 0x04, 0x0D, 0x0F, 0x1C or 0x1F raises `reg_wr` in the next cycle, with that address on `reg_waddr` and the byte on `reg_wdata`. Writes to any other address produce no pulse.
- R10: At most one of `asm_commit`, `freq_commit`, `reg_wr` and the bits of `duty_commit` is high in a cycle. Each pulse lasts exactly one cycle.
- R11: When `addr_stb` and `data_stb` are high in the same cycle, the address strobe is taken and no data transfer happens.
- R12: After reset the board is unselected, the address is 0, the assembly register is 0 and no pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| board_sel | input | 3 | This board's select code |
| addr_stb | input | 1 | Address byte present on host_wdata this cycle |
| data_stb | input | 1 | Data byte transfer this cycle |
| wr_en | input | 1 | 1 = data strobe is a write, 0 = read |
| host_wdata | input | 8 | Address or write data byte from host |
| enc_pos | input | 96 | Four 24-bit encoder latches, axis 0 in the low bits |
| aux_in | input | 24 | Three auxiliary read bytes |
| host_rdata | output | 8 | Read data for the current address |
| rdata_oe | output | 1 | Board selected, read data driven |
| asm_value | output | 24 | Assembly register contents |
| asm_commit | output | 1 | 24-bit value completed |
| duty_commit | output | 4 | Per-axis 16-bit duty commit |
| duty_value | output | 16 | Duty payload |
| freq_commit | output | 1 | 16-bit frequency commit |
| freq_value | output | 16 | Frequency payload |
| reg_wr | output | 1 | Single-byte register write strobe |
| reg_waddr | output | 5 | Address of single-byte write |
| reg_wdata | output | 8 | Data of single-byte write |

## Verification
Two collisions matter here: an address strobe arriving in the same cycle as a data strobe, and a commit caused by one byte while the next byte already moves the address. The bench raises both strobes together, once on a single-byte register address and once on a duty high-byte address. It then confirms that no write pulse appears, and that read data matches the newly loaded address rather than its successor. Back-to-back burst writes across every address show that each completing byte yields exactly one pulse while the following byte only updates the assembly register.

// File: rtl/regport_pkg.sv
package regport_pkg;

    // Byte width of the host bus and of every register slot
    localparam int BYTE_W = 8;
    // Width of two-byte destination values (duty, frequency)
    localparam int PAIR_W = 16;

    // What a write at the current address does
    typedef enum logic [2:0] {
        WK_NONE,
        WK_ASM_BYTE,
        WK_ASM_DONE,
        WK_PAIR_LO,
        WK_DUTY_HI,
        WK_FREQ_HI,
        WK_SINGLE
    } wr_kind_e;

endpackage

// File: rtl/regport_addr.sv
module regport_addr #(
    parameter int ADDR_W  = 5,
    parameter int BOARD_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BOARD_W-1:0]        board_sel,
    input  logic                      addr_stb,
    input  logic                      data_stb,
    input  logic [ADDR_W+BOARD_W-1:0] host_wdata,
    output logic [ADDR_W-1:0]         cur_addr,
    output logic                      selected,
    output logic                      xfer
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              sel;
    } addr_st_t;

    addr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        xfer = 1'b0;
        if (addr_stb) begin
            // address strobe wins over a coincident data strobe
            st_d.addr = host_wdata[ADDR_W-1:0];
            st_d.sel  = (host_wdata[ADDR_W+BOARD_W-1:ADDR_W] == board_sel);
        end else if (data_stb && st_q.sel) begin
            xfer      = 1'b1;
            st_d.addr = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_addr = st_q.addr;
    assign selected = st_q.sel;

endmodule

// File: rtl/regport_wdec.sv
module regport_wdec
    import regport_pkg::*;
#(
    parameter int                  ADDR_W       = 5,
    parameter int                  AXES         = 4,
    parameter int                  ASM_BYTES    = 3,
    parameter int                  DUTY_BASE    = 16,
    parameter int                  FREQ_LO_ADDR = 29,
    parameter int                  FREQ_HI_ADDR = 30,
    parameter logic [(1<<ADDR_W)-1:0] SINGLE_MASK = 32'h9000_A018
) (
    input  logic [ADDR_W-1:0]          cur_addr,
    output wr_kind_e                   kind,
    output logic [$clog2(AXES)-1:0]    axis
);

    localparam int AX_W     = $clog2(AXES);
    localparam int DUTY_END = DUTY_BASE + 2 * AXES;

    int a;

    always_comb begin
        a    = int'(cur_addr);
        kind = WK_NONE;
        axis = '0;
        if (a < ASM_BYTES - 1) begin
            kind = WK_ASM_BYTE;
        end else if (a == ASM_BYTES - 1) begin
            kind = WK_ASM_DONE;
        end else if (a >= DUTY_BASE && a < DUTY_END) begin
            axis = AX_W'((a - DUTY_BASE) >>> 1);
            kind = (((a - DUTY_BASE) & 1) == 1) ? WK_DUTY_HI : WK_PAIR_LO;
        end else if (a == FREQ_LO_ADDR) begin
            kind = WK_PAIR_LO;
        end else if (a == FREQ_HI_ADDR) begin
            kind = WK_FREQ_HI;
        end else if (SINGLE_MASK[cur_addr]) begin
            kind = WK_SINGLE;
        end
    end

endmodule

// File: rtl/regport_commit.sv
module regport_commit
    import regport_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int AXES      = 4,
    parameter int ASM_BYTES = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       xfer,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          cur_addr,
    input  logic [BYTE_W-1:0]          wdata,
    input  wr_kind_e                   kind,
    input  logic [$clog2(AXES)-1:0]    axis,
    output logic [ASM_BYTES*BYTE_W-1:0] asm_value,
    output logic                       asm_commit,
    output logic [AXES-1:0]            duty_commit,
    output logic [PAIR_W-1:0]          duty_value,
    output logic                       freq_commit,
    output logic [PAIR_W-1:0]          freq_value,
    output logic                       reg_wr,
    output logic [ADDR_W-1:0]          reg_waddr,
    output logic [BYTE_W-1:0]          reg_wdata
);

    localparam int ASM_W = ASM_BYTES * BYTE_W;

    typedef struct packed {
        logic [ASM_W-1:0]  asm_r;
        logic              asm_c;
        logic [AXES-1:0]   duty_c;
        logic [PAIR_W-1:0] duty_v;
        logic              freq_c;
        logic [PAIR_W-1:0] freq_v;
        logic              reg_c;
        logic [ADDR_W-1:0] reg_a;
        logic [BYTE_W-1:0] reg_v;
    } cm_st_t;

    cm_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.asm_c  = 1'b0;
        st_d.duty_c = '0;
        st_d.freq_c = 1'b0;
        st_d.reg_c  = 1'b0;
        if (xfer && wr_en) begin
            unique case (kind)
                WK_ASM_BYTE, WK_ASM_DONE: begin
                    for (int i = 0; i < ASM_BYTES; i++) begin
                        if (cur_addr == ADDR_W'(i)) begin
                            st_d.asm_r[i*BYTE_W +: BYTE_W] = wdata;
                        end
                    end
                    st_d.asm_c = (kind == WK_ASM_DONE);
                end
                WK_PAIR_LO: begin
                    st_d.asm_r[BYTE_W-1:0] = wdata;
                end
                WK_DUTY_HI: begin
                    st_d.duty_c[axis] = 1'b1;
                    st_d.duty_v       = {wdata, st_q.asm_r[BYTE_W-1:0]};
                end
                WK_FREQ_HI: begin
                    st_d.freq_c = 1'b1;
                    st_d.freq_v = {wdata, st_q.asm_r[BYTE_W-1:0]};
                end
                WK_SINGLE: begin
                    st_d.reg_c = 1'b1;
                    st_d.reg_a = cur_addr;
                    st_d.reg_v = wdata;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign asm_value   = st_q.asm_r;
    assign asm_commit  = st_q.asm_c;
    assign duty_commit = st_q.duty_c;
    assign duty_value  = st_q.duty_v;
    assign freq_commit = st_q.freq_c;
    assign freq_value  = st_q.freq_v;
    assign reg_wr      = st_q.reg_c;
    assign reg_waddr   = st_q.reg_a;
    assign reg_wdata   = st_q.reg_v;

endmodule

// File: rtl/regport_rdmux.sv
module regport_rdmux
    import regport_pkg::*;
#(
    parameter int                ADDR_W    = 5,
    parameter int                AXES      = 4,
    parameter int                ENC_W     = 24,
    parameter int                AUX_BYTES = 3,
    parameter int                ID_ADDR   = 15,
    parameter logic [BYTE_W-1:0] ID_CODE   = 8'h52
) (
    input  logic [ADDR_W-1:0]          cur_addr,
    input  logic                       selected,
    input  logic [AXES*ENC_W-1:0]      enc_pos,
    input  logic [AUX_BYTES*BYTE_W-1:0] aux_in,
    output logic [BYTE_W-1:0]          host_rdata
);

    localparam int NREG      = 1 << ADDR_W;
    localparam int ENC_BYTES = AXES * ENC_W / BYTE_W;
    localparam int AUX_BASE  = ENC_BYTES;

    logic [BYTE_W-1:0] rd_tbl [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g < ENC_BYTES) begin : g_enc
            assign rd_tbl[g] = enc_pos[g*BYTE_W +: BYTE_W];
        end else if (g >= AUX_BASE && g < AUX_BASE + AUX_BYTES) begin : g_aux
            assign rd_tbl[g] = aux_in[(g-AUX_BASE)*BYTE_W +: BYTE_W];
        end else if (g == ID_ADDR) begin : g_id
            assign rd_tbl[g] = ID_CODE;
        end else begin : g_zero
            assign rd_tbl[g] = '0;
        end
    end

    assign host_rdata = selected ? rd_tbl[cur_addr] : '0;

endmodule

// File: rtl/regport_top.sv
module regport_top
    import regport_pkg::*;
#(
    parameter int                ADDR_W       = 5,
    parameter int                BOARD_W      = 3,
    parameter int                AXES         = 4,
    parameter int                ENC_W        = 24,
    parameter int                AUX_BYTES    = 3,
    parameter int                DUTY_BASE    = 16,
    parameter int                FREQ_LO_ADDR = 29,
    parameter int                FREQ_HI_ADDR = 30,
    parameter int                ID_ADDR      = 15,
    parameter logic [BYTE_W-1:0] ID_CODE      = 8'h52,
    parameter logic [(1<<ADDR_W)-1:0] SINGLE_MASK = 32'h9000_A018
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BOARD_W-1:0]          board_sel,
    input  logic                        addr_stb,
    input  logic                        data_stb,
    input  logic                        wr_en,
    input  logic [BYTE_W-1:0]           host_wdata,
    input  logic [AXES*ENC_W-1:0]       enc_pos,
    input  logic [AUX_BYTES*BYTE_W-1:0] aux_in,
    output logic [BYTE_W-1:0]           host_rdata,
    output logic                        rdata_oe,
    output logic [ENC_W-1:0]            asm_value,
    output logic                        asm_commit,
    output logic [AXES-1:0]             duty_commit,
    output logic [PAIR_W-1:0]           duty_value,
    output logic                        freq_commit,
    output logic [PAIR_W-1:0]           freq_value,
    output logic                        reg_wr,
    output logic [ADDR_W-1:0]           reg_waddr,
    output logic [BYTE_W-1:0]           reg_wdata
);

    localparam int ASM_BYTES = ENC_W / BYTE_W;
    localparam int AX_W      = $clog2(AXES);

    logic [ADDR_W-1:0] cur_addr;
    logic              selected;
    logic              xfer;
    wr_kind_e          kind;
    logic [AX_W-1:0]   axis;

    regport_addr #(
        .ADDR_W (ADDR_W),
        .BOARD_W(BOARD_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .board_sel (board_sel),
        .addr_stb  (addr_stb),
        .data_stb  (data_stb),
        .host_wdata(host_wdata),
        .cur_addr  (cur_addr),
        .selected  (selected),
        .xfer      (xfer)
    );

    regport_wdec #(
        .ADDR_W      (ADDR_W),
        .AXES        (AXES),
        .ASM_BYTES   (ASM_BYTES),
        .DUTY_BASE   (DUTY_BASE),
        .FREQ_LO_ADDR(FREQ_LO_ADDR),
        .FREQ_HI_ADDR(FREQ_HI_ADDR),
        .SINGLE_MASK (SINGLE_MASK)
    ) u_wdec (
        .cur_addr(cur_addr),
        .kind    (kind),
        .axis    (axis)
    );

    regport_commit #(
        .ADDR_W   (ADDR_W),
        .AXES     (AXES),
        .ASM_BYTES(ASM_BYTES)
    ) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer       (xfer),
        .wr_en      (wr_en),
        .cur_addr   (cur_addr),
        .wdata      (host_wdata),
        .kind       (kind),
        .axis       (axis),
        .asm_value  (asm_value),
        .asm_commit (asm_commit),
        .duty_commit(duty_commit),
        .duty_value (duty_value),
        .freq_commit(freq_commit),
        .freq_value (freq_value),
        .reg_wr     (reg_wr),
        .reg_waddr  (reg_waddr),
        .reg_wdata  (reg_wdata)
    );

    regport_rdmux #(
        .ADDR_W   (ADDR_W),
        .AXES     (AXES),
        .ENC_W    (ENC_W),
        .AUX_BYTES(AUX_BYTES),
        .ID_ADDR  (ID_ADDR),
        .ID_CODE  (ID_CODE)
    ) u_rdmux (
        .cur_addr  (cur_addr),
        .selected  (selected),
        .enc_pos   (enc_pos),
        .aux_in    (aux_in),
        .host_rdata(host_rdata)
    );

    assign rdata_oe = selected;

endmodule

// File: rtl/regport_chk.sv
module regport_chk #(
    parameter int ADDR_W  = 5,
    parameter int BOARD_W = 3,
    parameter int AXES    = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [BOARD_W-1:0]        board_sel,
    input logic                      addr_stb,
    input logic                      data_stb,
    input logic                      wr_en,
    input logic [ADDR_W+BOARD_W-1:0] host_wdata,
    input logic [7:0]                host_rdata,
    input logic                      rdata_oe,
    input logic [ADDR_W-1:0]         cur_addr,
    input logic                      asm_commit,
    input logic [AXES-1:0]           duty_commit,
    input logic                      freq_commit,
    input logic                      reg_wr
);

    logic [AXES+2:0] pulses;
    assign pulses = {duty_commit, freq_commit, asm_commit, reg_wr};

    // R1
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |=> cur_addr == $past(host_wdata[ADDR_W-1:0]));

    // R1
    board_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |=> rdata_oe == ($past(host_wdata[ADDR_W+BOARD_W-1:ADDR_W]) == $past(board_sel)));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && !addr_stb && rdata_oe) |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_stb && !(data_stb && rdata_oe)) |=> $stable(cur_addr));

    // R3
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> host_rdata == 8'h00);

    // R10
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses));

    // R11
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulses) |-> $past(data_stb && wr_en && !addr_stb && rdata_oe));

    // R10
    duty_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|duty_commit) |=> (duty_commit & $past(duty_commit)) == '0);

endmodule

bind regport_top regport_chk #(
    .ADDR_W (ADDR_W),
    .BOARD_W(BOARD_W),
    .AXES   (AXES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .board_sel  (board_sel),
    .addr_stb   (addr_stb),
    .data_stb   (data_stb),
    .wr_en      (wr_en),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .rdata_oe   (rdata_oe),
    .cur_addr   (cur_addr),
    .asm_commit (asm_commit),
    .duty_commit(duty_commit),
    .freq_commit(freq_commit),
    .reg_wr     (reg_wr)
);

// File: tb/regport_top_test.sv
`timescale 1ns/1ps
module regport_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  board_sel = 3'b010;
    logic        addr_stb = 1'b0;
    logic        data_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [95:0] enc_pos = '0;
    logic [23:0] aux_in = '0;
    logic [7:0]  host_rdata;
    logic        rdata_oe;
    logic [23:0] asm_value;
    logic        asm_commit;
    logic [3:0]  duty_commit;
    logic [15:0] duty_value;
    logic        freq_commit;
    logic [15:0] freq_value;
    logic        reg_wr;
    logic [4:0]  reg_waddr;
    logic [7:0]  reg_wdata;

    regport_top uut (
        .clk(clk), .rst_n(rst_n), .board_sel(board_sel),
        .addr_stb(addr_stb), .data_stb(data_stb), .wr_en(wr_en),
        .host_wdata(host_wdata), .enc_pos(enc_pos), .aux_in(aux_in),
        .host_rdata(host_rdata), .rdata_oe(rdata_oe),
        .asm_value(asm_value), .asm_commit(asm_commit),
        .duty_commit(duty_commit), .duty_value(duty_value),
        .freq_commit(freq_commit), .freq_value(freq_value),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [23:0] asm_m = '0;
    localparam logic [7:0] SELB = 8'b010_00000;
    localparam logic [7:0] OTHB = 8'b101_00000;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        if (a < 12) return enc_pos[a*8 +: 8];
        if (a >= 12 && a < 15) return aux_in[(a-12)*8 +: 8];
        if (a == 15) return 8'h52;
        return 8'h00;
    endfunction

    task automatic astb(input logic [7:0] b);
        @(negedge clk);
        host_wdata = b;
        addr_stb = 1'b1;
        @(negedge clk);
        addr_stb = 1'b0;
    endtask

    task automatic dstb(input logic w, input logic [7:0] b);
        @(negedge clk);
        wr_en = w;
        host_wdata = b;
        data_stb = 1'b1;
        @(negedge clk);
        data_stb = 1'b0;
    endtask

    task automatic quiet_chk(input string tag);
        chk(tag, {reg_wr, freq_commit, asm_commit, duty_commit}, 32'h0);
    endtask

    task automatic rd_check(input int a);
        chk("R4/R5 rdata", host_rdata, exp_rd(a));
        chk("R1 oe", rdata_oe, 1'b1);
        dstb(1'b0, 8'h00);
    endtask

    task automatic wr_check(input int a, input logic [7:0] b);
        logic       e_asm = 1'b0;
        logic [3:0] e_duty = '0;
        logic [15:0] e_dv = '0;
        logic       e_freq = 1'b0;
        logic [15:0] e_fv = '0;
        logic       e_reg = 1'b0;
        if (a < 3) begin
            asm_m[a*8 +: 8] = b;
            e_asm = (a == 2);
        end else if (a >= 16 && a < 24) begin
            if ((a % 2) == 0) asm_m[7:0] = b;
            else begin
                e_duty = 4'(1 << ((a - 16) / 2));
                e_dv = {b, asm_m[7:0]};
            end
        end else if (a == 29) begin
            asm_m[7:0] = b;
        end else if (a == 30) begin
            e_freq = 1'b1;
            e_fv = {b, asm_m[7:0]};
        end else if (a == 3 || a == 4 || a == 13 || a == 15 || a == 28 || a == 31) begin
            e_reg = 1'b1;
        end
        dstb(1'b1, b);
        chk("R6 asm_value", asm_value, asm_m);
        chk("R6 asm_commit", asm_commit, e_asm);
        chk("R7 duty_commit", duty_commit, e_duty);
        if (e_duty != 0) chk("R7 duty_value", duty_value, e_dv);
        chk("R8 freq_commit", freq_commit, e_freq);
        if (e_freq) chk("R8 freq_value", freq_value, e_fv);
        chk("R9 reg_wr", reg_wr, e_reg);
        if (e_reg) chk("R9 reg_waddr/data", {reg_waddr, reg_wdata}, {5'(a), b});
        @(negedge clk);
        quiet_chk("R10 pulse width");
    endtask

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 oe", rdata_oe, 1'b0);
        chk("R12 rdata", host_rdata, 8'h00);
        chk("R12 asm", asm_value, 24'h0);
        quiet_chk("R12 pulses");

        // R4 R5 R2: read sweep through all addresses and past the wrap
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 12; i++) enc_pos[i*8 +: 8] = 8'(i * 17 + 3) ^ (p != 0 ? 8'hFF : 8'h00);
            aux_in = 24'hC3C2C1 ^ (p != 0 ? 24'h5A5A5A : 24'h0);
            astb(SELB);
            for (int i = 0; i < 33; i++) rd_check(i % 32);
        end

        // R3: unselected board ignores data strobes
        astb(OTHB);
        chk("R3 oe", rdata_oe, 1'b0);
        chk("R3 rdata", host_rdata, 8'h00);
        for (int i = 0; i < 3; i++) begin
            dstb(1'b1, 8'hAA);
            quiet_chk("R3 pulses");
            chk("R3 asm unchanged", asm_value, asm_m);
        end
        astb(OTHB | 8'h11);
        dstb(1'b1, 8'h77);
        quiet_chk("R3 duty ignored");
        chk("R3 rdata quiet", host_rdata, 8'h00);

        // R6..R9 and R2 wrap: burst writes over every address
        for (int p = 0; p < 3; p++) begin
            astb(SELB);
            for (int i = 0; i < 32; i++) wr_check(i, 8'((i * 7 + p * 53) ^ 8'hA5));
            wr_check(0, 8'(8'h3C + p));
        end

        // R7: duty burst with extreme bytes
        astb(SELB | 8'h10);
        for (int i = 0; i < 8; i++) wr_check(16 + i, (i % 2 == 0) ? 8'hFF : 8'h00);
        astb(SELB | 8'h10);
        for (int i = 0; i < 8; i++) wr_check(16 + i, (i % 2 == 0) ? 8'h00 : 8'hFF);

        // R8: frequency pair then R9 at 0x1F then wrap to 0
        astb(SELB | 8'h1D);
        wr_check(29, 8'h34);
        wr_check(30, 8'h12);
        wr_check(31, 8'h9E);
        wr_check(0, 8'h11);

        // R11: coincident address and data strobes
        @(negedge clk);
        host_wdata = SELB | 8'h03;
        wr_en = 1'b1;
        addr_stb = 1'b1;
        data_stb = 1'b1;
        @(negedge clk);
        addr_stb = 1'b0;
        data_stb = 1'b0;
        quiet_chk("R11 no write");
        chk("R11 addr not stepped", host_rdata, exp_rd(3));
        @(negedge clk);
        host_wdata = SELB | 8'h11;
        addr_stb = 1'b1;
        data_stb = 1'b1;
        @(negedge clk);
        addr_stb = 1'b0;
        data_stb = 1'b0;
        quiet_chk("R11 no duty");
        wr_check(17, 8'h5D);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule